// File: doc/BRIEF.md
# Pseudo-Random Sequence Lane Checker with Bit-Error and Window Counters

This block sits on the receive side of one serial lane, after the deserializer. It takes parallel words with a qualifying valid strobe and checks them against one of five maximal-length pseudo-random sequences. It has no seed input. While it is hunting, it rebuilds the sequence state from the bits it receives. Once a run of words has been predicted without error, it declares lock and then runs its own sequence freely, so that each corrupted bit counts exactly once.

Two counters support bit-error-ratio measurement. A saturating error counter adds up mismatched bits. A timer counts the valid words seen inside a measurement window. The window is opened and closed by command pulses, and it can also close on its own when the timer reaches a programmed limit. Margin-sweep software clears the counters, opens a window, waits for it to close and reads both counters. It repeats this for each sampling phase and offset it wants to compare.

Top module: `prbs_lane_checker`

## Requirements
- R1: `pat_sel_i` picks the sequence by the recurrence s[k] = s[k-N] xor s[k-M]. The codes are 0 for (N,M)=(7,6), 1 for (9,5), 2 for (11,9), 3 for (23,18) and 4 for (31,28); codes 5 to 7 act as code 4. Bit 0 of `rx_data_i` is the oldest bit of the word.
- R2: While hunting, the prediction history is filled from the received bits. `locked_o` rises after LOCK_WORDS consecutive valid words with no mismatch. It rises only in the cycle after a valid word.
- R3: While locked, the history is fed from predicted bits. `locked_o` falls after UNLOCK_WORDS consecutive valid words that each hold at least one mismatch. A clean word restarts that run.
- R4: Each valid word adds the number of set bits of (received xor predicted) to `err_cnt_o`. This happens only while locked and while the window is active. Words seen while hunting leave the counter unchanged.
- R5: `err_cnt_o` saturates at all ones instead of wrapping, and it never decreases except on clear.
- R6: `time_cnt_o` rises by one for each valid word while `active_o` is high, and holds otherwise. `start_i` raises `active_o` from the next cycle. `stop_i` lowers it from the next cycle and wins over `start_i`.
- R7: With a nonzero `time_limit_i`, the valid word that takes `time_cnt_o` to the limit also lowers `active_o` in the next cycle. A limit of 0 means the window has no limit.
- R8: `clear_i` zeroes both counters, returns the checker to hunting with an empty history in the next cycle, and discards any word presented in that cycle. It leaves `active_o` unchanged.
- R9: After reset, the counters are zero and `locked_o` and `active_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pat_sel_i | input | 3 | Sequence select code |
| start_i | input | 1 | Open the measurement window |
| stop_i | input | 1 | Close the measurement window |
| clear_i | input | 1 | Zero the counters and restart hunting |
| time_limit_i | input | TIME_W | Window length in words, 0 for none |
| rx_data_i | input | DATA_W | Received word, bit 0 oldest |
| rx_valid_i | input | 1 | Received word is valid |
| err_cnt_o | output | ERR_W | Saturating mismatched-bit count |
| time_cnt_o | output | TIME_W | Valid words counted in the window |
| locked_o | output | 1 | Checker is locked to the sequence |
| active_o | output | 1 | Measurement window is open |

## Verification
The bench builds the block with 16-bit words, an 8-bit error counter, a 16-bit timer, LOCK_WORDS of 4 and UNLOCK_WORDS of 3. With the narrow error counter, saturation at 255 is reached after sixteen fully corrupted words. With the short lock and unlock runs, every pattern locks within a dozen words and a three-word error burst drops lock. Because the timer is short, the automatic window close is checked with a limit of five words.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
   localparam int unsigned HIST_W = 31;
   localparam int unsigned TAP_W  = 5;

   typedef enum logic [2:0] {
      SEQ_O7  = 3'd0,
      SEQ_O9  = 3'd1,
      SEQ_O11 = 3'd2,
      SEQ_O23 = 3'd3,
      SEQ_O31 = 3'd4
   } seq_sel_e;

   // history index of s[k-N]; h[0] holds the most recent bit
   function automatic logic [TAP_W-1:0] tap_far(input logic [2:0] sel);
      case (sel)
         SEQ_O7:  tap_far = 5'd6;
         SEQ_O9:  tap_far = 5'd8;
         SEQ_O11: tap_far = 5'd10;
         SEQ_O23: tap_far = 5'd22;
         default: tap_far = 5'd30;
      endcase
   endfunction

   // history index of s[k-M]
   function automatic logic [TAP_W-1:0] tap_near(input logic [2:0] sel);
      case (sel)
         SEQ_O7:  tap_near = 5'd5;
         SEQ_O9:  tap_near = 5'd4;
         SEQ_O11: tap_near = 5'd8;
         SEQ_O23: tap_near = 5'd17;
         default: tap_near = 5'd27;
      endcase
   endfunction
endpackage

// File: rtl/prbs_chk_predict.sv
module prbs_chk_predict
   import prbs_chk_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [2:0]        sel_i,
   input  logic [HIST_W-1:0] hist_i,
   input  logic [DATA_W-1:0] rx_i,
   input  logic              use_rx_i,
   output logic [DATA_W-1:0] exp_o,
   output logic [HIST_W-1:0] hist_o
);
   logic [TAP_W-1:0]  far_idx, near_idx;
   logic [HIST_W-1:0] stage [0:DATA_W];

   assign far_idx  = tap_far(sel_i);
   assign near_idx = tap_near(sel_i);
   assign stage[0] = hist_i;

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic fb;
      assign exp_o[b]   = stage[b][far_idx] ^ stage[b][near_idx];
      assign fb         = use_rx_i ? rx_i[b] : exp_o[b];
      assign stage[b+1] = {stage[b][HIST_W-2:0], fb};
   end

   assign hist_o = stage[DATA_W];
endmodule

// File: rtl/prbs_chk_lock.sv
module prbs_chk_lock #(
   parameter int unsigned LOCK_WORDS   = 8,
   parameter int unsigned UNLOCK_WORDS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic valid_i,
   input  logic bad_i,
   output logic locked_o
);
   localparam int unsigned GW = $clog2(LOCK_WORDS + 1);
   localparam int unsigned BW = $clog2(UNLOCK_WORDS + 1);

   typedef enum logic {ST_HUNT, ST_LOCK} lock_st_e;

   lock_st_e      st_q;
   logic [GW-1:0] good_q;
   logic [BW-1:0] bad_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_HUNT;
         good_q <= '0;
         bad_q  <= '0;
      end else if (clear_i) begin
         st_q   <= ST_HUNT;
         good_q <= '0;
         bad_q  <= '0;
      end else if (valid_i) begin
         if (st_q == ST_HUNT) begin
            if (bad_i) begin
               good_q <= '0;
            end else if (good_q == GW'(LOCK_WORDS - 1)) begin
               st_q   <= ST_LOCK;
               good_q <= '0;
               bad_q  <= '0;
            end else begin
               good_q <= good_q + 1'b1;
            end
         end else begin
            if (!bad_i) begin
               bad_q <= '0;
            end else if (bad_q == BW'(UNLOCK_WORDS - 1)) begin
               st_q   <= ST_HUNT;
               bad_q  <= '0;
               good_q <= '0;
            end else begin
               bad_q <= bad_q + 1'b1;
            end
         end
      end
   end

   assign locked_o = (st_q == ST_LOCK);
endmodule

// File: rtl/prbs_chk_meter.sv
module prbs_chk_meter #(
   parameter int unsigned ERR_W = 32,
   parameter int unsigned TIME_W = 48,
   parameter int unsigned PC_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              valid_i,
   input  logic              locked_i,
   input  logic [PC_W-1:0]   err_bits_i,
   input  logic [TIME_W-1:0] limit_i,
   output logic [ERR_W-1:0]  err_cnt_o,
   output logic [TIME_W-1:0] time_cnt_o,
   output logic              active_o
);
   logic              act_q;
   logic [ERR_W-1:0]  err_q;
   logic [TIME_W-1:0] tim_q;
   logic              take_word, limit_hit;
   logic [TIME_W-1:0] tim_inc;
   logic [ERR_W:0]    err_sum;

   assign take_word = act_q & valid_i & ~clear_i;
   assign tim_inc   = tim_q + 1'b1;
   assign limit_hit = take_word && (limit_i != '0) && (tim_inc == limit_i);
   assign err_sum   = {1'b0, err_q} + (ERR_W+1)'(err_bits_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         err_q <= '0;
         tim_q <= '0;
      end else begin
         if (stop_i)          act_q <= 1'b0;
         else if (limit_hit)  act_q <= 1'b0;
         else if (start_i)    act_q <= 1'b1;

         if (clear_i)        tim_q <= '0;
         else if (take_word) tim_q <= tim_inc;

         if (clear_i)
            err_q <= '0;
         else if (take_word && locked_i)
            err_q <= err_sum[ERR_W] ? '1 : err_sum[ERR_W-1:0];
      end
   end

   assign err_cnt_o  = err_q;
   assign time_cnt_o = tim_q;
   assign active_o   = act_q;
endmodule

// File: rtl/prbs_lane_checker.sv
module prbs_lane_checker
   import prbs_chk_pkg::*;
#(
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned ERR_W        = 32,
   parameter int unsigned TIME_W       = 48,
   parameter int unsigned LOCK_WORDS   = 8,
   parameter int unsigned UNLOCK_WORDS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        pat_sel_i,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              clear_i,
   input  logic [TIME_W-1:0] time_limit_i,
   input  logic [DATA_W-1:0] rx_data_i,
   input  logic              rx_valid_i,
   output logic [ERR_W-1:0]  err_cnt_o,
   output logic [TIME_W-1:0] time_cnt_o,
   output logic              locked_o,
   output logic              active_o
);
   localparam int unsigned PC_W = $clog2(DATA_W + 1);

   initial begin
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
      assert (ERR_W >= PC_W) else $error("ERR_W narrower than a word's error count");
      assert (TIME_W >= 2) else $error("TIME_W too small");
      assert (LOCK_WORDS >= 1 && UNLOCK_WORDS >= 1) else $error("run lengths must be nonzero");
   end

   logic [HIST_W-1:0] hist_q, hist_nx;
   logic [DATA_W-1:0] exp_w, miss_w;
   logic [PC_W-1:0]   miss_cnt;
   logic              word_bad;

   prbs_chk_predict #(.DATA_W(DATA_W)) u_pred (
      .sel_i   (pat_sel_i),
      .hist_i  (hist_q),
      .rx_i    (rx_data_i),
      .use_rx_i(~locked_o),
      .exp_o   (exp_w),
      .hist_o  (hist_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hist_q <= '0;
      else if (clear_i)    hist_q <= '0;
      else if (rx_valid_i) hist_q <= hist_nx;
   end

   assign miss_w   = exp_w ^ rx_data_i;
   assign word_bad = |miss_w;

   always_comb begin
      miss_cnt = '0;
      for (int i = 0; i < DATA_W; i++) miss_cnt = miss_cnt + PC_W'(miss_w[i]);
   end

   prbs_chk_lock #(.LOCK_WORDS(LOCK_WORDS), .UNLOCK_WORDS(UNLOCK_WORDS)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear_i),
      .valid_i (rx_valid_i),
      .bad_i   (word_bad),
      .locked_o(locked_o)
   );

   prbs_chk_meter #(.ERR_W(ERR_W), .TIME_W(TIME_W), .PC_W(PC_W)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (clear_i),
      .start_i   (start_i),
      .stop_i    (stop_i),
      .valid_i   (rx_valid_i),
      .locked_i  (locked_o),
      .err_bits_i(miss_cnt),
      .limit_i   (time_limit_i),
      .err_cnt_o (err_cnt_o),
      .time_cnt_o(time_cnt_o),
      .active_o  (active_o)
   );
endmodule

// File: rtl/prbs_lane_checker_sva.sv
module prbs_lane_checker_sva #(
   parameter int unsigned ERR_W  = 32,
   parameter int unsigned TIME_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clear_i,
   input logic              rx_valid_i,
   input logic [TIME_W-1:0] time_limit_i,
   input logic [ERR_W-1:0]  err_cnt_o,
   input logic [TIME_W-1:0] time_cnt_o,
   input logic              locked_o,
   input logic              active_o
);
   AST_LOCK_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(rx_valid_i)); // R2

   AST_UNLOCK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_o) |-> ($past(rx_valid_i) || $past(clear_i))); // R3

   AST_ERR_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (!(locked_o && active_o && rx_valid_i) && !clear_i) |=> $stable(err_cnt_o)); // R4

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> err_cnt_o >= $past(err_cnt_o)); // R5

   AST_TIME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!(active_o && rx_valid_i) && !clear_i) |=> $stable(time_cnt_o)); // R6

   AST_LIMIT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && rx_valid_i && !clear_i && time_limit_i != '0
       && TIME_W'(time_cnt_o + 1'b1) == time_limit_i) |=> !active_o); // R7

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (err_cnt_o == '0 && time_cnt_o == '0 && !locked_o)); // R8
endmodule

bind prbs_lane_checker prbs_lane_checker_sva #(.ERR_W(ERR_W), .TIME_W(TIME_W)) sva_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .clear_i     (clear_i),
   .rx_valid_i  (rx_valid_i),
   .time_limit_i(time_limit_i),
   .err_cnt_o   (err_cnt_o),
   .time_cnt_o  (time_cnt_o),
   .locked_o    (locked_o),
   .active_o    (active_o)
);

// File: tb/prbs_lane_checker_tb_top.sv
`timescale 1ns/1ps
module prbs_lane_checker_tb_top;
   localparam int DW = 16, EW = 8, TW = 16;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [2:0]    sel = 3'd0;
   logic          start = 1'b0, stop = 1'b0, clr = 1'b0, vld = 1'b0;
   logic [TW-1:0] limit = '0;
   logic [DW-1:0] rx = '0;
   logic [EW-1:0] err;
   logic [TW-1:0] tim;
   logic          locked, active;

   int total = 0, bad = 0;
   logic [30:0] gh;

   always #2.5 clk = ~clk;

   prbs_lane_checker #(.DATA_W(DW), .ERR_W(EW), .TIME_W(TW),
                       .LOCK_WORDS(4), .UNLOCK_WORDS(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .pat_sel_i(sel), .start_i(start), .stop_i(stop),
      .clear_i(clr), .time_limit_i(limit), .rx_data_i(rx), .rx_valid_i(vld),
      .err_cnt_o(err), .time_cnt_o(tim), .locked_o(locked), .active_o(active));

   typedef struct packed {
      logic [2:0]  vsel;
      logic [15:0] vmask;
      logic [7:0]  verr;
   } vec_t;

   // four corrupted words per pattern, each with vmask flipped
   localparam vec_t VECS [5] = '{
      '{3'd0, 16'h0001, 8'd4},
      '{3'd1, 16'h8000, 8'd4},
      '{3'd2, 16'h0101, 8'd8},
      '{3'd3, 16'h00F0, 8'd16},
      '{3'd4, 16'hFFFF, 8'd64}
   };

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic next_word(output logic [DW-1:0] w);
      int n, m;
      logic b;
      case (sel)
         3'd0: begin n = 7;  m = 6;  end
         3'd1: begin n = 9;  m = 5;  end
         3'd2: begin n = 11; m = 9;  end
         3'd3: begin n = 23; m = 18; end
         default: begin n = 31; m = 28; end
      endcase
      for (int i = 0; i < DW; i++) begin
         b = gh[n-1] ^ gh[m-1];
         w[i] = b;
         gh = {gh[29:0], b};
      end
   endtask

   task automatic send(input logic [DW-1:0] w);
      rx = w; vld = 1'b1;
      @(negedge clk);
      vld = 1'b0;
   endtask

   task automatic send_seq(input logic [DW-1:0] mask);
      logic [DW-1:0] w;
      next_word(w);
      send(w ^ mask);
   endtask

   task automatic cmd(input logic c, input logic s, input logic p);
      clr = c; start = s; stop = p;
      @(negedge clk);
      clr = 1'b0; start = 1'b0; stop = 1'b0;
   endtask

   task automatic relock(input logic [2:0] s);
      sel = s; gh = '1;
      cmd(1'b1, 1'b0, 1'b0);
      for (int k = 0; k < 12; k++) send_seq('0);
   endtask

   initial begin
      #(5.0 * 150000);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 err after reset", err, 0);
      chk("R9 time after reset", tim, 0);
      chk("R9 locked after reset", locked, 0);
      chk("R9 active after reset", active, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: window closed, words do not advance the timer
      gh = '1;
      send_seq('0); send_seq('0);
      chk("R6 timer holds while closed", tim, 0);
      cmd(1'b0, 1'b1, 1'b0);
      chk("R6 start opens window", active, 1);

      // table: lock on each pattern, then alternate corrupted and clean words
      foreach (VECS[v]) begin
         relock(VECS[v].vsel);
         chk($sformatf("R2 lock pattern %0d", VECS[v].vsel), locked, 1);
         for (int k = 0; k < 8; k++) send_seq((k % 2 == 0) ? VECS[v].vmask : '0);
         chk($sformatf("R1 R4 errors pattern %0d", VECS[v].vsel), err, VECS[v].verr);
         chk($sformatf("R3 lock held pattern %0d", VECS[v].vsel), locked, 1);
         chk($sformatf("R6 time pattern %0d", VECS[v].vsel), tim, 20);
      end

      // R8: clear
      cmd(1'b1, 1'b0, 1'b0);
      chk("R8 err cleared", err, 0);
      chk("R8 time cleared", tim, 0);
      chk("R8 lock dropped", locked, 0);
      chk("R8 window kept", active, 1);

      // R4: errors while hunting are not counted (all-ones never fits any pattern)
      for (int k = 0; k < 5; k++) send('1);
      chk("R4 no count while hunting", err, 0);
      chk("R2 no lock on bad words", locked, 0);
      chk("R6 hunting words timed", tim, 5);

      // R3: burst of three bad words drops lock
      relock(3'd0);
      chk("R2 relock pattern 0", locked, 1);
      send_seq(16'h0001); send_seq(16'h0001);
      chk("R3 still locked after two", locked, 1);
      chk("R4 two single-bit errors", err, 2);
      send_seq(16'h0001);
      chk("R3 unlocked after three", locked, 0);
      chk("R4 third word counted", err, 3);
      send_seq(16'h0003);
      chk("R4 ignored after unlock", err, 3);

      // R5: saturation at 255
      relock(3'd4);
      for (int k = 0; k < 15; k++) begin
         send_seq(16'hFFFF); send_seq('0);
      end
      chk("R5 count before saturation", err, 240);
      send_seq(16'hFFFF);
      chk("R5 saturated", err, 255);
      send_seq('0); send_seq(16'hFFFF);
      chk("R5 stays saturated", err, 255);
      chk("R5 still locked", locked, 1);

      // R7: automatic close at the limit
      cmd(1'b1, 1'b0, 1'b1);
      limit = 16'd5;
      cmd(1'b0, 1'b1, 1'b0);
      for (int k = 0; k < 4; k++) send_seq('0);
      chk("R7 open before limit", active, 1);
      send_seq('0);
      chk("R7 closed at limit", active, 0);
      send_seq('0); send_seq('0);
      chk("R7 timer stops at limit", tim, 5);

      // R7: limit 0 means unlimited; R6: stop wins over start
      limit = '0;
      cmd(1'b0, 1'b1, 1'b0);
      for (int k = 0; k < 3; k++) send_seq('0);
      chk("R7 no limit counts on", tim, 8);
      cmd(1'b0, 1'b1, 1'b1);
      chk("R6 stop wins over start", active, 0);
      send_seq('0);
      chk("R6 stopped window holds timer", tim, 8);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule